// File: doc/BRIEF.md
# Dithered Fractional-Duty PWM Generator

This block turns an 8-bit duty value into a pulse-width-modulated output whose average high fraction over one full period is exactly duty/256. The full period of 256 clocks is split into equal modulation slots. A coarse part of the duty value sets the high time of every slot. The remaining low-order dither bits choose how many of the leading slots get one extra high clock. The output therefore repeats at the slot rate rather than the full-period rate, which keeps ripple low after filtering and still gives the full 8-bit average resolution.

Two splits are available. In the two-slot split, seven coarse bits drive 128-clock slots and one dither bit applies to slot 0. In the four-slot split, six coarse bits drive 64-clock slots and two dither bits give the extra clock to slots 0 up to ac-1. The duty value and the split are captured once per full period, so one period never mixes two settings. Deasserting the enable forces the output low and restarts the period counter.

Top module: `dither_pwm`

## Requirements
- R1: While enabled, the period counter advances once per clock and wraps every 256 clocks, so the output pattern for a fixed setting repeats every 256 enabled clocks.
- R2: With split_i = 0, coarse = duty_i[7:1] and ac = duty_i[0]. The period has two 128-clock slots. Slot i (i = 0, 1) is high for coarse+1 clocks when i < ac, and for coarse clocks otherwise.
- R3: With split_i = 1, coarse = duty_i[7:2] and ac = duty_i[1:0]. The period has four 64-clock slots. Slot i (i = 0..3) is high for coarse+1 clocks when i < ac, and for coarse clocks otherwise.
- R4: Inside each slot the output is high from the slot's first clock for its high time, then low until the slot ends.
- R5: duty_i and split_i are sampled only at the first clock of a period. A change made during a period takes effect at the next period.
- R6: A slot whose high time is zero stays low for its whole length. A duty value of 0 gives a constantly low output.
- R7: The output is low after reset. One clock after en_i is sampled low, the output is low and the counter is back at position 0. The first enabled clock after that starts a new period.
- R8: In either split, the number of high clocks in one full period equals the 8-bit duty value.
- R9: The output value for period position k appears one clock after the edge at which the counter holds k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable; low holds the output low and clears the counter |
| split_i | input | 1 | 0: two 128-clock slots with 1 dither bit; 1: four 64-clock slots with 2 dither bits |
| duty_i | input | 8 | Duty value in 1/256 units |
| pwm_o | output | 1 | Registered PWM output |

## Verification
Every output bit is due one clock after the rising edge that samples an enabled counter position. The bench drives inputs on falling edges. A driver task queues the expected bit for each position at the moment it drives that position. A monitor pops and compares on the falling edge after the next rising edge, and it does this only when the bench recorded en_i high at that rising edge. Otherwise the monitor checks that the output is low. The bench applies a mid-period duty change and queues the old value's bits until the period wraps, so the next-period sampling rule is checked at the exact boundary. When a period's last position is popped, the monitor compares the period's high count with the duty value.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;

  localparam int unsigned DUTY_W = 8;

  typedef enum logic {
    SPLIT_TWO  = 1'b0,
    SPLIT_FOUR = 1'b1
  } dpwm_split_e;

  function automatic int unsigned dither_bits(dpwm_split_e split);
    return (split == SPLIT_FOUR) ? 32'd2 : 32'd1;
  endfunction

  // High time, in clocks, of the slot that contains period position pcnt.
  function automatic logic [DUTY_W:0] slot_high(logic [DUTY_W-1:0] duty,
                                                dpwm_split_e split,
                                                logic [DUTY_W-1:0] pcnt);
    int unsigned db;
    int unsigned coarse;
    int unsigned ac;
    int unsigned slot;
    db     = dither_bits(split);
    coarse = 32'(duty) >> db;
    ac     = 32'(duty) & ((32'd1 << db) - 32'd1);
    slot   = 32'(pcnt) >> (DUTY_W - db);
    return (DUTY_W+1)'(coarse + ((slot < ac) ? 32'd1 : 32'd0));
  endfunction

  // Offset of period position pcnt inside its slot.
  function automatic logic [DUTY_W:0] slot_pos(dpwm_split_e split,
                                               logic [DUTY_W-1:0] pcnt);
    int unsigned db;
    db = dither_bits(split);
    return (DUTY_W+1)'(32'(pcnt) & ((32'd1 << (DUTY_W - db)) - 32'd1));
  endfunction

endpackage

// File: rtl/dpwm_timebase.sv
module dpwm_timebase
  import dpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  output logic [DUTY_W-1:0] cnt_o,
  output logic              frame_start_o
);

  localparam logic [DUTY_W-1:0] CNT_ONE = DUTY_W'(1);

  logic [DUTY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o         = cnt_q;
  assign frame_start_o = en_i && (cnt_q == '0);

endmodule

// File: rtl/dpwm_shadow.sv
module dpwm_shadow
  import dpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_start_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  logic              split_i,
  output logic [DUTY_W-1:0] act_duty_o,
  output dpwm_split_e       act_split_o,
  output logic [DUTY_W-1:0] held_duty_o
);

  logic [DUTY_W-1:0] duty_q;
  dpwm_split_e       split_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q  <= '0;
      split_q <= SPLIT_TWO;
    end else if (frame_start_i) begin
      duty_q  <= duty_i;
      split_q <= dpwm_split_e'(split_i);
    end
  end

  // The first clock of a period uses the new inputs directly.
  assign act_duty_o  = frame_start_i ? duty_i : duty_q;
  assign act_split_o = frame_start_i ? dpwm_split_e'(split_i) : split_q;
  assign held_duty_o = duty_q;

endmodule

// File: rtl/dpwm_shaper.sv
module dpwm_shaper
  import dpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [DUTY_W-1:0] cnt_i,
  input  logic [DUTY_W-1:0] duty_i,
  input  dpwm_split_e       split_i,
  output logic              level_o,
  output logic              pwm_o
);

  logic [DUTY_W:0] high_time;
  logic [DUTY_W:0] pos;
  logic            pwm_q;

  assign high_time = slot_high(duty_i, split_i, cnt_i);
  assign pos       = slot_pos(split_i, cnt_i);
  assign level_o   = pos < high_time;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pwm_q <= 1'b0;
    else         pwm_q <= en_i && level_o;
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/dither_pwm.sv
module dither_pwm
  import dpwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              split_i,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);

  logic [DUTY_W-1:0] cnt;
  logic              frame_start;
  logic [DUTY_W-1:0] act_duty;
  dpwm_split_e       act_split;
  logic [DUTY_W-1:0] held_duty;
  logic              level;

  dpwm_timebase u_tb (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .cnt_o         (cnt),
    .frame_start_o (frame_start)
  );

  dpwm_shadow u_shadow (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_start_i (frame_start),
    .duty_i        (duty_i),
    .split_i       (split_i),
    .act_duty_o    (act_duty),
    .act_split_o   (act_split),
    .held_duty_o   (held_duty)
  );

  dpwm_shaper u_shaper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .cnt_i   (cnt),
    .duty_i  (act_duty),
    .split_i (act_split),
    .level_o (level),
    .pwm_o   (pwm_o)
  );

endmodule

// File: rtl/dpwm_checker.sv
module dpwm_checker
  import dpwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic [DUTY_W-1:0] duty_i,
  input logic              pwm_o,
  input logic [DUTY_W-1:0] cnt,
  input logic              frame_start,
  input logic [DUTY_W-1:0] held_duty
);

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !pwm_o) else $error("output high after disable"); // R7

  AST_COUNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt == '0)) else $error("counter not restarted"); // R7

  AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt != '1) |=> (cnt == DUTY_W'($past(cnt) + 1'b1))) else $error("counter step"); // R1

  AST_COUNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && cnt == '1) |=> (cnt == '0)) else $error("counter wrap"); // R1

  AST_SHADOW_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_start |=> $stable(held_duty)) else $error("duty changed mid-period"); // R5

  AST_ZERO_DUTY_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && duty_i == '0) |=> !pwm_o) else $error("zero duty drove high"); // R6

  AST_SLOT_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_start && duty_i != '0) |=> pwm_o) else $error("period start not high"); // R4

endmodule

bind dither_pwm dpwm_checker u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .duty_i      (duty_i),
  .pwm_o       (pwm_o),
  .cnt         (cnt),
  .frame_start (frame_start),
  .held_duty   (held_duty)
);

// File: tb/dither_pwm_tb.sv
`timescale 1ns/1ps
module dither_pwm_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       split = 1'b0;
  logic [7:0] duty = 8'd0;
  logic       pwm;

  int checks = 0;
  int errors = 0;
  logic en_at_edge = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit exp;
    int pos;
    int duty;
    string req;
  } item_t;

  item_t sb[$];
  int highs = 0;

  always #2 clk = ~clk;

  dither_pwm u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .split_i (split),
    .duty_i  (duty),
    .pwm_o   (pwm)
  );

  // Expected level, restated with division instead of shifts.
  function automatic bit model(int d, bit sp, int k);
    int slots = sp ? 4 : 2;
    int len   = 256 / slots;
    int cs    = d / slots;
    int ac    = d % slots;
    int idx   = k / len;
    int off   = k % len;
    int ht    = cs + ((idx < ac) ? 1 : 0);
    return off < ht;
  endfunction

  always @(posedge clk) en_at_edge <= en;

  // Monitor (R9: value for position k appears one edge after the counter holds k).
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (en_at_edge) begin
        if (sb.size() == 0) begin
          errors++; checks++;
          $display("FAIL R9: output with empty scoreboard, actual=%0b expected=none", pwm);
        end else begin
          item_t it;
          it = sb.pop_front();
          checks++;
          if (pwm !== it.exp) begin
            errors++;
            $display("FAIL %s: duty=%0d pos=%0d actual=%0b expected=%0b",
                     it.req, it.duty, it.pos, pwm, it.exp);
          end
          if (it.pos == 0) highs = 0;
          if (pwm === 1'b1) highs++;
          if (it.pos == 255) begin
            checks++;
            if (highs != it.duty) begin
              errors++;
              $display("FAIL R8: high clocks per period actual=%0d expected=%0d", highs, it.duty);
            end
          end
        end
      end else begin
        checks++;
        if (pwm !== 1'b0) begin
          errors++;
          $display("FAIL R7: output while disabled actual=%0b expected=0", pwm);
        end
      end
    end
  end

  // Driver: one full period; optional duty change at position chg_at (R5).
  task automatic run_period(int d, bit sp, string req, int chg_at = -1, int d_new = 0);
    for (int k = 0; k < 256; k++) begin
      item_t it;
      if (k == 0) begin
        duty = 8'(d);
        split = sp;
        en = 1'b1;
      end
      if (k == chg_at) begin
        duty = 8'(d_new);
        split = ~sp;
      end
      it.exp = model(d, sp, k);
      it.pos = k;
      it.duty = d;
      it.req = (chg_at >= 0 && k >= chg_at) ? "R5" : req;
      sb.push_back(it);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (pwm !== 1'b0) begin
      errors++;
      $display("FAIL R7: reset output actual=%0b expected=0", pwm);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // Two-slot split (R2), including a full-high slot and a zero slot (R6).
    run_period(8'h85, 1'b0, "R2");
    run_period(8'h85, 1'b0, "R1");
    run_period(1, 1'b0, "R6");
    run_period(255, 1'b0, "R2");
    run_period(0, 1'b0, "R6");
    run_period(128, 1'b0, "R4");
    // Four-slot split (R3).
    run_period(8'h4E, 1'b1, "R3");
    run_period(3, 1'b1, "R6");
    run_period(255, 1'b1, "R3");
    run_period(2, 1'b1, "R3");
    // Mid-period change; the new setting only shows in the next period (R5).
    run_period(8'h40, 1'b0, "R5", 100, 8'h91);
    run_period(8'h91, 1'b1, "R5");
    // Disable mid-period, then restart from position 0 (R7).
    en = 1'b1; duty = 8'd200; split = 1'b0;
    for (int k = 0; k < 50; k++) begin
      item_t it;
      it.exp = model(200, 1'b0, k);
      it.pos = k;
      it.duty = 200;
      it.req = "R7";
      sb.push_back(it);
      @(posedge clk);
      @(negedge clk);
    end
    en = 1'b0;
    repeat (6) @(negedge clk);
    run_period(77, 1'b0, "R7");
    en = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9: undrained items actual=%0d expected=0", sb.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule